// File: doc/BRIEF.md
# Shared Memory Bank Conflict Serializer

This block takes the shared-memory word addresses of one warp, together with a mask of the threads that are active, and turns them into a sequence of conflict-free passes. Each word address belongs to one bank, chosen by its low-order bits. Within one pass, each bank serves exactly one address. Threads that request the same word in the same bank are merged and served together by broadcast. The number of passes is therefore the largest count of distinct words that any single bank is asked for.

Each pass is offered on a valid/ready handshake. A pass carries four things:
- which banks are enabled;
- the word each enabled bank must read;
- the set of threads served in that pass;
- a flag on the final pass.

The total pass count for the warp is shown beside the passes. The storage arrays and the return of data are left to the surrounding logic. A new warp is taken only after the final pass of the current warp has been consumed. Conflicts are judged only inside one warp.

Top module: `bank_conflict_serializer`

## Requirements
- R1: With the default 32 banks, a word address maps to bank (address mod 32), which is its 5 low bits. Bit b of `pass_bank_en_o`, and the field `pass_bank_addr_o[b*ADDR_W +: ADDR_W]`, belong to bank b.
- R2: When every active thread hits a different bank, the warp completes in exactly one pass. That pass serves all active threads and has `pass_last_o` high.
- R3: When k active threads request k different words of the same bank, they are served in k passes, one thread per pass, in ascending thread order.
- R4: Active threads that request an identical word are all served in the same pass, by broadcast.
- R5: `pass_count_o` equals the maximum, over all banks, of the number of distinct words requested by active threads in that bank. It is valid from the cycle after the warp is accepted until the next warp is accepted, and it is 0 after reset.
- R6: In every pass, each bank that still has unserved threads serves the word of its lowest-numbered unserved thread, together with every unserved thread requesting that word. No thread is served twice.
- R7: Inactive threads (mask bit 0) never appear in any thread mask. Their addresses have no effect on the passes or on the pass count.
- R8: A warp with no active thread is accepted and produces no pass. `pass_count_o` becomes 0 and `req_ready_o` stays high.
- R9: `req_ready_o` is low from the cycle after a warp with active threads is accepted until its final pass (`pass_last_o` high) has been taken. A request offered in that interval is not accepted.
- R10: While `pass_valid_o` is high and `pass_ready_i` is low, the offered pass holds all of its fields unchanged.
- R11: After reset, `pass_valid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Warp request valid |
| req_ready_o | output | 1 | Block can accept a warp |
| req_mask_i | input | THREADS | Active-thread mask, bit t for thread t |
| req_addr_i | input | THREADS*ADDR_W | Word address of thread t at [t*ADDR_W +: ADDR_W] |
| pass_valid_o | output | 1 | A pass is offered |
| pass_ready_i | input | 1 | Consumer takes the offered pass |
| pass_thread_mask_o | output | THREADS | Threads served in this pass |
| pass_bank_en_o | output | BANKS | Banks accessed in this pass |
| pass_bank_addr_o | output | BANKS*ADDR_W | Word selected for bank b at [b*ADDR_W +: ADDR_W] |
| pass_last_o | output | 1 | This is the warp's final pass |
| pass_count_o | output | CNT_W | Total passes for the current warp |

## Verification
The warp patterns are chosen so that each one isolates a single rule:
- Unit-stride addresses spread over all banks and must fit in one pass.
- A stride equal to the bank count piles every thread onto one bank and forces full serialization in thread order.
- A single shared address checks that broadcast merging collapses the pass to one.
- A stride of two yields two-way conflicts, which separates the pass count from the thread count.
- A mix of repeated and distinct words in one bank shows that merging and serialization work together.
- A half-active warp whose idle threads would conflict heavily exposes any leak from inactive lanes.
- The all-idle warp covers the zero-pass case.
- A stalled consumer, offered a competing request, checks that the pass holds and that the second warp is blocked.
- Pseudo-random narrow address ranges compare every pass against an independently computed schedule.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned DEF_THREADS = 32;
  localparam int unsigned DEF_BANKS   = 32;
  localparam int unsigned DEF_ADDR_W  = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bcs_state_e;
endpackage

// File: rtl/bcs_pass_count.sv
// Pass count = max over banks of distinct active words in that bank.
module bcs_pass_count #(
  parameter int unsigned THREADS = 32,
  parameter int unsigned BANKS   = 32,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CNT_W   = 6
) (
  input  logic [THREADS*ADDR_W-1:0] addr_i,
  input  logic [THREADS-1:0]        mask_i,
  output logic [CNT_W-1:0]          count_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic [THREADS-1:0] first;
  logic [CNT_W-1:0]   bank_cnt [BANKS];

  // thread is first active requester of its word
  always_comb begin
    first = mask_i;
    for (int t = 0; t < THREADS; t++) begin
      for (int j = 0; j < t; j++) begin
        if (mask_i[j] && addr_i[j*ADDR_W +: ADDR_W] == addr_i[t*ADDR_W +: ADDR_W])
          first[t] = 1'b0;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int t = 0; t < THREADS; t++) begin
        if (first[t] && addr_i[t*ADDR_W +: BANK_W] == BANK_W'(b))
          cnt = cnt + CNT_W'(1);
      end
    end
    assign bank_cnt[b] = cnt;
  end

  always_comb begin
    count_o = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (bank_cnt[b] > count_o) count_o = bank_cnt[b];
    end
  end
endmodule

// File: rtl/bcs_pass_pick.sv
// One pass: each bank serves the word of its lowest pending thread plus sharers.
module bcs_pass_pick #(
  parameter int unsigned THREADS = 32,
  parameter int unsigned BANKS   = 32,
  parameter int unsigned ADDR_W  = 16
) (
  input  logic [THREADS*ADDR_W-1:0] addr_i,
  input  logic [THREADS-1:0]        pend_i,
  output logic [THREADS-1:0]        served_o,
  output logic [BANKS-1:0]          bank_en_o,
  output logic [BANKS*ADDR_W-1:0]   bank_addr_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic [THREADS-1:0] leader;

  always_comb begin
    leader = pend_i;
    for (int t = 0; t < THREADS; t++) begin
      for (int j = 0; j < t; j++) begin
        if (pend_i[j] && addr_i[j*ADDR_W +: BANK_W] == addr_i[t*ADDR_W +: BANK_W])
          leader[t] = 1'b0;
      end
    end
  end

  // a leader always precedes or equals the threads it serves
  always_comb begin
    served_o = '0;
    for (int t = 0; t < THREADS; t++) begin
      for (int j = 0; j <= t; j++) begin
        if (pend_i[t] && leader[j] && addr_i[j*ADDR_W +: ADDR_W] == addr_i[t*ADDR_W +: ADDR_W])
          served_o[t] = 1'b1;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              en;
    logic [ADDR_W-1:0] sel;
    always_comb begin
      en  = 1'b0;
      sel = '0;
      for (int t = 0; t < THREADS; t++) begin
        if (leader[t] && addr_i[t*ADDR_W +: BANK_W] == BANK_W'(b)) begin
          en  = 1'b1;
          sel = sel | addr_i[t*ADDR_W +: ADDR_W];
        end
      end
    end
    assign bank_en_o[b]                  = en;
    assign bank_addr_o[b*ADDR_W +: ADDR_W] = sel;
  end
endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
  import bcs_pkg::*;
#(
  parameter  int unsigned THREADS = DEF_THREADS,
  parameter  int unsigned BANKS   = DEF_BANKS,
  parameter  int unsigned ADDR_W  = DEF_ADDR_W,
  localparam int unsigned CNT_W   = $clog2(THREADS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [THREADS-1:0]        req_mask_i,
  input  logic [THREADS*ADDR_W-1:0] req_addr_i,
  output logic                      pass_valid_o,
  input  logic                      pass_ready_i,
  output logic [THREADS-1:0]        pass_thread_mask_o,
  output logic [BANKS-1:0]          pass_bank_en_o,
  output logic [BANKS*ADDR_W-1:0]   pass_bank_addr_o,
  output logic                      pass_last_o,
  output logic [CNT_W-1:0]          pass_count_o
);
  bcs_state_e                state_q;
  logic [THREADS*ADDR_W-1:0] addr_q;
  logic [THREADS-1:0]        mask_q;
  logic [THREADS-1:0]        pend_q;
  logic [THREADS-1:0]        served;
  logic [THREADS-1:0]        pend_next;
  logic                      accept;
  logic                      take;

  assign req_ready_o  = (state_q == ST_IDLE);
  assign pass_valid_o = (state_q == ST_BUSY);
  assign accept       = req_valid_i && req_ready_o;
  assign take         = pass_valid_o && pass_ready_i;
  assign pend_next    = pend_q & ~served;
  assign pass_last_o  = (pend_next == '0);
  assign pass_thread_mask_o = served;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      mask_q  <= req_mask_i;
      pend_q  <= req_mask_i;
      state_q <= (req_mask_i != '0) ? ST_BUSY : ST_IDLE;
    end else if (take) begin
      pend_q <= pend_next;
      if (pass_last_o) state_q <= ST_IDLE;
    end
  end

  bcs_pass_pick #(
    .THREADS(THREADS), .BANKS(BANKS), .ADDR_W(ADDR_W)
  ) u_pick (
    .addr_i     (addr_q),
    .pend_i     (pend_q),
    .served_o   (served),
    .bank_en_o  (pass_bank_en_o),
    .bank_addr_o(pass_bank_addr_o)
  );

  bcs_pass_count #(
    .THREADS(THREADS), .BANKS(BANKS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_count (
    .addr_i (addr_q),
    .mask_i (mask_q),
    .count_o(pass_count_o)
  );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int unsigned THREADS = 32,
  parameter int unsigned BANKS   = 32,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CNT_W   = 6
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      req_ready_o,
  input logic [THREADS-1:0]        req_mask_i,
  input logic                      pass_valid_o,
  input logic                      pass_ready_i,
  input logic [THREADS-1:0]        pass_thread_mask_o,
  input logic [BANKS-1:0]          pass_bank_en_o,
  input logic [BANKS*ADDR_W-1:0]   pass_bank_addr_o,
  input logic                      pass_last_o,
  input logic [CNT_W-1:0]          pass_count_o
);
  logic [THREADS-1:0] seen_q;
  logic [THREADS-1:0] done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      done_q <= '0;
    end else if (req_valid_i && req_ready_o) begin
      seen_q <= req_mask_i;
      done_q <= '0;
    end else if (pass_valid_o && pass_ready_i) begin
      done_q <= done_q | pass_thread_mask_o;
    end
  end

  // R9
  busy_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o |-> !req_ready_o);

  // R9
  last_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o && pass_ready_i && pass_last_o |=> req_ready_o && !pass_valid_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o && !pass_ready_i |=> pass_valid_o && $stable(pass_thread_mask_o)
      && $stable(pass_bank_en_o) && $stable(pass_bank_addr_o) && $stable(pass_last_o));

  // R8
  empty_warp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_mask_i == '0 |=> !pass_valid_o && pass_count_o == '0);

  // R7
  inactive_never_served_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o |-> (pass_thread_mask_o & ~seen_q) == '0);

  // R6
  no_double_serve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o |-> (pass_thread_mask_o & done_q) == '0 && pass_thread_mask_o != '0
      && $countones(pass_bank_en_o) <= $countones(pass_thread_mask_o));

  // R5
  count_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o |-> pass_count_o != '0);
endmodule

bind bank_conflict_serializer bcs_checker #(
  .THREADS(THREADS), .BANKS(BANKS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_bcs_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_valid_i       (req_valid_i),
  .req_ready_o       (req_ready_o),
  .req_mask_i        (req_mask_i),
  .pass_valid_o      (pass_valid_o),
  .pass_ready_i      (pass_ready_i),
  .pass_thread_mask_o(pass_thread_mask_o),
  .pass_bank_en_o    (pass_bank_en_o),
  .pass_bank_addr_o  (pass_bank_addr_o),
  .pass_last_o       (pass_last_o),
  .pass_count_o      (pass_count_o)
);

// File: tb/bank_conflict_serializer_test.sv
module bank_conflict_serializer_test;
  localparam int T  = 32;
  localparam int B  = 32;
  localparam int AW = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [T-1:0]    req_mask;
  logic [T*AW-1:0] req_addr;
  logic            pass_valid;
  logic            pass_ready;
  logic [T-1:0]    pass_tm;
  logic [B-1:0]    pass_be;
  logic [B*AW-1:0] pass_ba;
  logic            pass_last;
  logic [CW-1:0]   pass_count;

  bank_conflict_serializer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_mask_i(req_mask), .req_addr_i(req_addr),
    .pass_valid_o(pass_valid), .pass_ready_i(pass_ready),
    .pass_thread_mask_o(pass_tm), .pass_bank_en_o(pass_be),
    .pass_bank_addr_o(pass_ba), .pass_last_o(pass_last),
    .pass_count_o(pass_count)
  );

  int total = 0;
  int bad   = 0;

  logic [AW-1:0]   a_in [T];
  logic [T-1:0]    m_in;
  logic [T-1:0]    e_tm [T+1];
  logic [B-1:0]    e_be [T+1];
  logic [B*AW-1:0] e_ba [T+1];
  int              e_n;
  logic [31:0]     lfsr = 32'hACE1_2468;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // schedule straight from R1/R6: bank = low 5 bits, lowest pending leads
  task automatic build_model();
    logic [T-1:0]    pend;
    logic [B-1:0]    be;
    logic [B*AW-1:0] ba;
    logic [T-1:0]    tm;
    pend = m_in;
    e_n  = 0;
    while (pend != '0) begin
      be = '0; ba = '0; tm = '0;
      for (int t = 0; t < T; t++) begin
        int bk = int'(a_in[t]) % B;
        if (pend[t] && !be[bk]) begin
          be[bk] = 1'b1;
          ba[bk*AW +: AW] = a_in[t];
        end
      end
      for (int t = 0; t < T; t++) begin
        int bk = int'(a_in[t]) % B;
        if (pend[t] && ba[bk*AW +: AW] == a_in[t]) tm[t] = 1'b1;
      end
      e_tm[e_n] = tm; e_be[e_n] = be; e_ba[e_n] = ba;
      pend = pend & ~tm;
      e_n++;
    end
  endtask

  task automatic check_pass(input string tag, input int p);
    int mb = 0;
    bit ok = (pass_ba == e_ba[p]);
    for (int b = B - 1; b >= 0; b--)
      if (pass_ba[b*AW +: AW] != e_ba[p][b*AW +: AW]) mb = b;
    chk(pass_valid == 1'b1, {tag, " R9 pass valid"}, 64'(pass_valid), 64'd1);
    chk(req_ready == 1'b0, {tag, " R9 busy blocks req"}, 64'(req_ready), 64'd0);
    chk(pass_tm == e_tm[p], {tag, " thread mask"}, 64'(pass_tm), 64'(e_tm[p]));
    chk(pass_be == e_be[p], {tag, " R1 bank enables"}, 64'(pass_be), 64'(e_be[p]));
    chk(ok, {tag, " R1 bank address"}, 64'(pass_ba[mb*AW +: AW]), 64'(e_ba[p][mb*AW +: AW]));
    chk(pass_last == (p == e_n - 1), {tag, " R9 last flag"}, 64'(pass_last), 64'(p == e_n - 1));
  endtask

  task automatic run_warp(input string tag, input int stall);
    logic [T-1:0]    s_tm;
    logic [B*AW-1:0] s_ba;
    logic [B-1:0]    s_be;
    build_model();
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R9 ready before warp"}, 64'(req_ready), 64'd1);
    for (int t = 0; t < T; t++) req_addr[t*AW +: AW] = a_in[t];
    req_mask  = m_in;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(pass_count == CW'(e_n), {tag, " R5 pass count"}, 64'(pass_count), 64'(e_n));
    if (e_n == 0)
      chk(!pass_valid && req_ready, {tag, " R8 empty warp idle"}, 64'({pass_valid, req_ready}), 64'b01);
    for (int p = 0; p < e_n; p++) begin
      if (stall > 0 && p == 0) begin
        pass_ready = 1'b0;
        s_tm = pass_tm; s_ba = pass_ba; s_be = pass_be;
        req_mask  = ~m_in;
        for (int t = 0; t < T; t++) req_addr[t*AW +: AW] = AW'(t * 64 + 5);
        req_valid = 1'b1;
        repeat (stall) @(negedge clk);
        chk(pass_tm == s_tm && pass_ba == s_ba && pass_be == s_be && pass_valid,
            {tag, " R10 stalled pass held"}, 64'(pass_tm), 64'(s_tm));
        chk(req_ready == 1'b0, {tag, " R9 req refused while busy"}, 64'(req_ready), 64'd0);
        req_valid  = 1'b0;
        pass_ready = 1'b1;
      end
      check_pass(tag, p);
      @(negedge clk);
    end
    chk(!pass_valid && req_ready, {tag, " R9 idle after last"}, 64'({pass_valid, req_ready}), 64'b01);
    chk(pass_count == CW'(e_n), {tag, " R5 count held"}, 64'(pass_count), 64'(e_n));
  endtask

  task automatic t_reset();
    chk(pass_valid == 1'b0, "R11 no pass after reset", 64'(pass_valid), 64'd0);
    chk(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
    chk(pass_count == '0, "R5 count zero after reset", 64'(pass_count), 64'd0);
  endtask

  task automatic t_bank_map();
    for (int t = 0; t < T; t++) a_in[t] = '0;
    a_in[9] = 16'h1234;
    m_in = 32'h0000_0200;
    build_model();
    chk(e_be[0] == 32'h0010_0000, "R1 model bank 20", 64'(e_be[0]), 64'h0010_0000);
    run_warp("R1 single thread bank 20", 0);
  endtask

  task automatic t_stride1();
    for (int t = 0; t < T; t++) a_in[t] = AW'(100 + t);
    m_in = '1;
    run_warp("R2 unit stride", 0);
  endtask

  task automatic t_same_bank();
    for (int t = 0; t < T; t++) a_in[t] = AW'(t * 32 + 7);
    m_in = '1;
    run_warp("R3 stride 32 one bank", 0);
  endtask

  task automatic t_broadcast();
    for (int t = 0; t < T; t++) a_in[t] = 16'h0ABC;
    m_in = '1;
    run_warp("R4 broadcast", 0);
  endtask

  task automatic t_stride2();
    for (int t = 0; t < T; t++) a_in[t] = AW'(2 * t);
    m_in = '1;
    run_warp("R5 stride 2", 0);
  endtask

  task automatic t_mixed();
    for (int t = 0; t < T; t++) a_in[t] = AW'((t % 4) * 32 + 3);
    m_in = '1;
    run_warp("R6 merge plus serialize", 0);
  endtask

  task automatic t_inactive();
    for (int t = 0; t < T; t++) a_in[t] = (t < 16) ? AW'(t) : AW'(t * 32);
    m_in = 32'h0000_FFFF;
    run_warp("R7 inactive lanes", 0);
  endtask

  task automatic t_empty();
    for (int t = 0; t < T; t++) a_in[t] = AW'(t * 32);
    m_in = '0;
    run_warp("R8 all inactive", 0);
  endtask

  task automatic t_stall();
    for (int t = 0; t < T; t++) a_in[t] = AW'((t % 3) * 32 + 11);
    m_in = 32'hF0F0_0F0F;
    run_warp("R10 backpressure", 3);
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++) begin
      for (int t = 0; t < T; t++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        a_in[t] = AW'(lfsr[7:0]);
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      m_in = lfsr;
      run_warp("R6 random", i % 2);
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_mask   = '0;
    req_addr   = '0;
    pass_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bank_map();
    t_stride1();
    t_same_bank();
    t_broadcast();
    t_stride2();
    t_mixed();
    t_inactive();
    t_empty();
    t_stall();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule